// File: doc/BRIEF.md
# Grouped External Interrupt Request Unit

This block turns a group of up to eight GPIO pins that are set up as interrupt inputs into one interrupt request for the CPU. The port supplies synchronized pin levels and a per-pin qualifier that marks which pins take part in the interrupt. The block merges the qualified pins into one group level, watches that level for the event chosen by a two-bit sensitivity setting, and records a detected event in a request latch that software can neither read nor write.

The latch clears in two ways. The interrupt controller pulses a vector-fetch acknowledge when it takes the interrupt. Software can also change the sensitivity setting, which discards a pending request. The group level is the AND of the qualified pins. One qualified pin held low therefore hides activity on every other pin of the group.

Top module: `extIrqGroup`

## Requirements
- R1: While `rstN` is low, and right after it falls, `irqReq` is 0.
- R2: The group level is the AND of `pinLevel[i]` over the pins with `pinIrqEn[i]` = 1. A pin with `pinIrqEn[i]` = 0 counts as 1. With no pin qualified, the group stays high and never raises a request.
- R3: While any qualified pin is low, level changes on the other pins do not reach the group level and raise no request.
- R4: With `sensSel` = 2'b00, a low group level sets the request in every cycle it is seen. An acknowledge taken while the group is still low leaves `irqReq` at 1.
- R5: With `sensSel` = 2'b01, only a low-to-high change of the group level sets the request.
- R6: With `sensSel` = 2'b10, only a high-to-low change of the group level sets the request.
- R7: With `sensSel` = 2'b11, a change of the group level in either direction sets the request.
- R8: Once set, `irqReq` stays at 1 until cleared. `vecFetchAck` = 1 in a cycle with no new event clears it on the next clock edge.
- R9: When a new event and `vecFetchAck` fall in the same cycle, `irqReq` stays at 1.
- R10: In a cycle where `sensSel` differs from its value one clock earlier, the request is cleared and no event is taken.
- R11: `irqReq` changes on the first clock edge after the inputs show the event. Edges are found by comparing the group level with its value at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinLevel | input | NUM_PINS | Synchronized pin levels |
| pinIrqEn | input | NUM_PINS | Per-pin interrupt qualifier (1 = pin takes part) |
| sensSel | input | 2 | Sensitivity: 00 low/falling, 01 rising, 10 falling, 11 both |
| vecFetchAck | input | 1 | One-cycle pulse when the CPU fetches this vector |
| irqReq | output | 1 | Interrupt request to the CPU |

## Verification
The bench targets masking. A design that ORs the pins, or that lets a disabled pin pull the group low, would raise requests while a qualified pin is held low, or would miss the rising edge seen when the last low pin is disqualified. It also targets the clear paths. An acknowledge that overrides a coincident event would lose an interrupt. A low-level mode that did not re-set after an acknowledge would drop a level that is still active. A sensitivity change that failed to discard a pending request would leave a stale interrupt behind. Finally, the bench checks the latency of one register and the previous-cycle edge compare, so an extra pipeline stage or a missing history register shows up as a shifted or absent request.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  localparam int SENS_W = 2;

  typedef enum logic [SENS_W-1:0] {
    SENS_LOW_FALL = 2'b00,
    SENS_RISE     = 2'b01,
    SENS_FALL     = 2'b10,
    SENS_BOTH     = 2'b11
  } sensMode_e;

  typedef struct packed {
    logic setReq;
    logic clrReq;
  } reqStrobe_t;
endpackage

// File: rtl/eirq_datapath.sv
module eirq_datapath
  import eirq_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinLevel,
  input  logic [NUM_PINS-1:0] pinIrqEn,
  input  logic [SENS_W-1:0]   sensSel,
  input  reqStrobe_t          strobe,
  output logic                groupNow,
  output logic                groupPrev,
  output logic                sensChanged,
  output logic                reqQ
);
  logic [NUM_PINS-1:0] pinGate;
  logic [SENS_W-1:0]   sensPrev;

  // Disqualified pins are forced high so they neither mask nor trigger.
  for (genvar i = 0; i < NUM_PINS; i++) begin : gPinGate
    assign pinGate[i] = pinLevel[i] | ~pinIrqEn[i];
  end

  assign groupNow    = &pinGate;
  assign sensChanged = (sensSel != sensPrev);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      groupPrev <= 1'b1;
    end else begin
      groupPrev <= groupNow;
    end
  end

  // Plain delay of the setting, so a change is seen against the real prior value.
  always_ff @(posedge clk) begin
    sensPrev <= sensSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqQ <= 1'b0;
    end else if (strobe.clrReq) begin
      reqQ <= 1'b0;
    end else if (strobe.setReq) begin
      reqQ <= 1'b1;
    end
  end
endmodule

// File: rtl/eirq_control.sv
module eirq_control
  import eirq_pkg::*;
(
  input  logic              groupNow,
  input  logic              groupPrev,
  input  logic [SENS_W-1:0] sensSel,
  input  logic              sensChanged,
  input  logic              vecFetchAck,
  output reqStrobe_t        strobe
);
  logic eventHit;
  logic riseSeen;
  logic fallSeen;

  assign riseSeen = groupNow & ~groupPrev;
  assign fallSeen = ~groupNow & groupPrev;

  always_comb begin
    unique case (sensMode_e'(sensSel))
      SENS_LOW_FALL: eventHit = ~groupNow;
      SENS_RISE:     eventHit = riseSeen;
      SENS_FALL:     eventHit = fallSeen;
      SENS_BOTH:     eventHit = riseSeen | fallSeen;
      default:       eventHit = 1'b0;
    endcase
  end

  // A setting change discards everything; otherwise a new event outranks the acknowledge.
  always_comb begin
    strobe.setReq = eventHit & ~sensChanged;
    strobe.clrReq = sensChanged | (vecFetchAck & ~eventHit);
  end
endmodule

// File: rtl/extIrqGroup.sv
module extIrqGroup
  import eirq_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinLevel,
  input  logic [NUM_PINS-1:0] pinIrqEn,
  input  logic [1:0]          sensSel,
  input  logic                vecFetchAck,
  output logic                irqReq
);
  reqStrobe_t strobe;
  logic groupNow;
  logic groupPrev;
  logic sensChanged;

  eirq_datapath #(.NUM_PINS(NUM_PINS)) uDatapath (
    .clk(clk), .rstN(rstN), .pinLevel(pinLevel), .pinIrqEn(pinIrqEn),
    .sensSel(sensSel), .strobe(strobe), .groupNow(groupNow),
    .groupPrev(groupPrev), .sensChanged(sensChanged), .reqQ(irqReq)
  );

  eirq_control uControl (
    .groupNow(groupNow), .groupPrev(groupPrev), .sensSel(sensSel),
    .sensChanged(sensChanged), .vecFetchAck(vecFetchAck), .strobe(strobe)
  );

  AST_NO_QUAL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(pinIrqEn) && (pinIrqEn == '0) && !irqReq) |=> !irqReq); // R2
  AST_MASK_BLOCKS_RISE: assert property (@(posedge clk) disable iff (!rstN)
    ((sensSel == SENS_RISE) && |(pinIrqEn & ~pinLevel)) |=> !$rose(irqReq)); // R3
  AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    ((sensSel == SENS_LOW_FALL) && $stable(sensSel) && !groupNow) |=> irqReq); // R4
  AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rstN)
    ((sensSel == SENS_RISE) && $stable(sensSel) && groupNow && !groupPrev) |=> irqReq); // R5
  AST_FALL_IGNORES_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    ((sensSel == SENS_FALL) && !irqReq && groupNow) |=> !irqReq); // R6
  AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    (vecFetchAck && groupNow && groupPrev) |=> !irqReq); // R8
  AST_EVENT_BEATS_ACK: assert property (@(posedge clk) disable iff (!rstN)
    ((sensSel == SENS_BOTH) && $stable(sensSel) && vecFetchAck && (groupNow != groupPrev)) |=> irqReq); // R9
  AST_SENS_CHANGE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (sensSel != $past(sensSel)) |=> !irqReq); // R10
endmodule

// File: tb/tb_extIrqGroup.sv
`timescale 1ns/1ps
module tb_extIrqGroup;
  localparam int NUM_PINS = 8;
  localparam int NVEC = 36;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NUM_PINS-1:0] pinLevel = '1;
  logic [NUM_PINS-1:0] pinIrqEn = '1;
  logic [1:0] sensSel = 2'b00;
  logic vecFetchAck = 1'b0;
  logic irqReq;

  int checkCount = 0;
  int failCount = 0;
  bit runDone = 1'b0;

  always #2.5 clk = ~clk;

  extIrqGroup #(.NUM_PINS(NUM_PINS)) dut (
    .clk(clk), .rstN(rstN), .pinLevel(pinLevel), .pinIrqEn(pinIrqEn),
    .sensSel(sensSel), .vecFetchAck(vecFetchAck), .irqReq(irqReq)
  );

  // Fields: pinLevel, pinIrqEn, sensSel, ack, expected irqReq after the edge, requirement number
  localparam logic [23:0] VEC [NVEC] = '{
    {8'hFF, 8'hFF, 2'b01, 1'b0, 1'b0, 4'd10}, // 0  setting change: R10
    {8'hFF, 8'hFF, 2'b01, 1'b0, 1'b0, 4'd5},  // 1  no edge: R5
    {8'hFE, 8'hFF, 2'b01, 1'b0, 1'b0, 4'd5},  // 2  fall ignored: R5
    {8'hFF, 8'hFF, 2'b01, 1'b0, 1'b1, 4'd5},  // 3  rise sets: R5
    {8'hFF, 8'hFF, 2'b01, 1'b0, 1'b1, 4'd8},  // 4  held: R8
    {8'hFF, 8'hFF, 2'b01, 1'b1, 1'b0, 4'd8},  // 5  ack clears: R8
    {8'h7F, 8'hFF, 2'b01, 1'b0, 1'b0, 4'd5},  // 6  fall ignored: R5
    {8'h7F, 8'h7F, 2'b01, 1'b0, 1'b1, 4'd2},  // 7  disqualified low pin lifts group: R2
    {8'h7F, 8'h7F, 2'b01, 1'b1, 1'b0, 4'd8},  // 8  ack clears: R8
    {8'h00, 8'h01, 2'b01, 1'b0, 1'b0, 4'd2},  // 9  single qualified pin low: R2
    {8'h01, 8'h01, 2'b01, 1'b0, 1'b1, 4'd2},  // 10 single qualified pin rises: R2
    {8'h01, 8'h01, 2'b10, 1'b0, 1'b0, 4'd10}, // 11 setting change discards: R10
    {8'h00, 8'h01, 2'b10, 1'b0, 1'b1, 4'd6},  // 12 fall sets: R6
    {8'h01, 8'h01, 2'b10, 1'b0, 1'b1, 4'd8},  // 13 rise leaves it pending: R8
    {8'h01, 8'h01, 2'b10, 1'b1, 1'b0, 4'd6},  // 14 ack clears: R6
    {8'h01, 8'h01, 2'b10, 1'b0, 1'b0, 4'd6},  // 15 idle: R6
    {8'h00, 8'h00, 2'b10, 1'b0, 1'b0, 4'd2},  // 16 none qualified: R2
    {8'hFF, 8'h00, 2'b10, 1'b0, 1'b0, 4'd2},  // 17 none qualified: R2
    {8'hFF, 8'hFF, 2'b11, 1'b0, 1'b0, 4'd10}, // 18 setting change: R10
    {8'hF7, 8'hFF, 2'b11, 1'b0, 1'b1, 4'd7},  // 19 fall sets: R7
    {8'hF7, 8'hFF, 2'b11, 1'b1, 1'b0, 4'd7},  // 20 ack, steady low: R7
    {8'hFF, 8'hFF, 2'b11, 1'b0, 1'b1, 4'd7},  // 21 rise sets: R7
    {8'hFE, 8'hFF, 2'b11, 1'b1, 1'b1, 4'd9},  // 22 event with ack: R9
    {8'hFE, 8'hFF, 2'b11, 1'b0, 1'b1, 4'd8},  // 23 held: R8
    {8'hFE, 8'hFF, 2'b11, 1'b1, 1'b0, 4'd8},  // 24 ack clears: R8
    {8'hFE, 8'hFF, 2'b01, 1'b0, 1'b0, 4'd10}, // 25 setting change: R10
    {8'hF6, 8'hFF, 2'b01, 1'b0, 1'b0, 4'd3},  // 26 masked pin 3 fall: R3
    {8'hFE, 8'hFF, 2'b01, 1'b0, 1'b0, 4'd3},  // 27 masked pin 3 rise: R3
    {8'hFE, 8'hFF, 2'b00, 1'b0, 1'b0, 4'd10}, // 28 change cycle takes no event: R10
    {8'hFE, 8'hFF, 2'b00, 1'b0, 1'b1, 4'd4},  // 29 low level sets: R4
    {8'hFE, 8'hFF, 2'b00, 1'b1, 1'b1, 4'd4},  // 30 ack while low: R4
    {8'hFF, 8'hFF, 2'b00, 1'b1, 1'b0, 4'd4},  // 31 ack after release: R4
    {8'hFF, 8'hFF, 2'b00, 1'b0, 1'b0, 4'd4},  // 32 high idle: R4
    {8'h7F, 8'hFF, 2'b00, 1'b0, 1'b1, 4'd4},  // 33 low sets: R4
    {8'h7F, 8'hFF, 2'b01, 1'b0, 1'b0, 4'd10}, // 34 change discards pending: R10
    {8'hFF, 8'hFF, 2'b01, 1'b0, 1'b1, 4'd11}  // 35 rise vs previous cycle: R11
  };

  task automatic checkReq(input logic expVal, input string tag);
    checkCount++;
    if (irqReq !== expVal) begin
      failCount++;
      $display("FAIL %s: irqReq actual=%b expected=%b at %0t", tag, irqReq, expVal, $time);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!runDone) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finishRun();
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    checkReq(1'b0, "R1");
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      pinLevel    = VEC[i][23:16];
      pinIrqEn    = VEC[i][15:8];
      sensSel     = VEC[i][7:6];
      vecFetchAck = VEC[i][5];
      @(negedge clk);
      checkReq(VEC[i][4], $sformatf("R%0d vec%0d", VEC[i][3:0], i));
    end

    // R1: reset in the middle of a pending request
    vecFetchAck = 1'b0;
    rstN = 1'b0;
    #1;
    checkReq(1'b0, "R1 async");
    @(negedge clk);
    checkReq(1'b0, "R1 held");

    // R11: latency of one register, edge against the previous cycle
    sensSel  = 2'b01;
    pinLevel = 8'hFE;
    pinIrqEn = 8'hFF;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkReq(1'b0, "R11 low");
    pinLevel = 8'hFF;
    #1;
    checkReq(1'b0, "R11 before edge");
    @(negedge clk);
    checkReq(1'b1, "R11 after edge");
    @(negedge clk);
    checkReq(1'b1, "R8 held");

    runDone = 1'b1;
    finishRun();
  end
endmodule